// File: doc/BRIEF.md
# Windowed Watchdog Timer with Scalers

This block is a watchdog timer that counts a slow clock-enable tick through two stages. The first stage divides the tick by 32 or by 128. The second stage divides that result by a power of two chosen by a 4-bit code. When both stages reach their terminal counts, the watchdog has expired. A normal-mode expiry produces a one-cycle reset request. An expiry while the system reports sleep or idle produces a one-cycle wake-up request instead. Either event sets a sticky timeout flag, which stays set until software clears it.

Software keeps the timer alive with a clear pulse. Power-save entry, power-save exit and clock-switch completion also restart the counter chain. A clear restarts it too, whether or not the clear was legal. In window mode, a clear is legal only in the final quarter of the timeout period. A clear that arrives earlier produces a reset request at once.

The timer runs when the hard enable is set. When the hard enable is clear, a software enable bit controls it, and system reset clears that bit. All pins are plain control and status signals. There is no data stream, so the block has no valid/ready handshake.

Top module: `wdog_window`

## Requirements
- R1: The first stage wraps after 32 ticks when `cfg_pre_long`=0 and after 128 ticks when `cfg_pre_long`=1. Cycles with `tick`=0 do not advance it.
- R2: For a postscale code n (0..15), the watchdog expires on the tick that completes (first-stage length) × 2^n ticks since the last restart.
- R3: A pulse on `kick`, `ps_enter`, `ps_exit` or `clk_sw_done` zeroes both stages. Counting restarts from zero on the next tick.
- R4: The timer is enabled when `cfg_force_en`=1 or when the software enable is 1. A cycle with `sw_en_wr`=1 loads `sw_en_din` into the software enable. Reset clears the software enable and all outputs.
- R5: An expiry while `sleep_idle`=0 drives `rst_req` high for exactly the one cycle that follows the expiring tick.
- R6: When `cfg_win_off`=0 and the timer is enabled, a `kick` outside the window drives `rst_req` high for one cycle on the next cycle. For code n≥1, the window is second-stage count ≥ (3·2^n)/4 (integer division). For code 0, the window is first-stage count ≥ 24 (short) or ≥ 96 (long).
- R7: An expiry while `sleep_idle`=1 drives `wake_req` high for one cycle instead of `rst_req`.
- R8: `to_flag` is set in the same cycle as any `rst_req` or `wake_req` pulse. It stays set until `flag_clr`=1. When a set and a clear arrive together, the set wins.
- R9: While disabled, both stages stay at zero, and no `rst_req` or `wake_req` pulse is produced.
- R10: With `cfg_win_off`=1, a `kick` at any count restarts the timer without a reset request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| tick | input | 1 | Slow clock enable that advances the first stage |
| cfg_pre_long | input | 1 | First-stage length: 0 selects 32, 1 selects 128 |
| cfg_post_code | input | 4 | Second-stage code n, which divides by 2^n |
| cfg_force_en | input | 1 | Hard enable |
| cfg_win_off | input | 1 | 1 disables window checking |
| sw_en_wr | input | 1 | Write strobe for the software enable |
| sw_en_din | input | 1 | Value written into the software enable |
| kick | input | 1 | Watchdog clear pulse |
| ps_enter | input | 1 | Power-save entry pulse |
| ps_exit | input | 1 | Power-save exit pulse |
| clk_sw_done | input | 1 | Clock-switch completion pulse |
| sleep_idle | input | 1 | High while the system is in sleep or idle |
| flag_clr | input | 1 | Software clear of the timeout flag |
| rst_req | output | 1 | One-cycle reset request |
| wake_req | output | 1 | One-cycle wake-up request |
| to_flag | output | 1 | Sticky timeout flag |

## Verification
The range assertions on both stages assume that configuration pins change only while the timer is disabled and its counts are held at zero. Changing them mid-count could leave a count above the new terminal value. The bench therefore disables the timer for two cycles around every configuration change. The restart assertion assumes the pulse inputs are single-cycle events, and the bench drives each of them for one cycle only. Its reference model follows the window, the wake/reset choice and the flag priority on every clock, including ticks that arrive only every third cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Outcome of one clock of watchdog decision logic
  typedef enum logic [1:0] {
    WD_NONE  = 2'd0,
    WD_RESET = 2'd1,
    WD_WAKE  = 2'd2
  } wd_evt_e;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int SHORT_LOG = 5,
  parameter int LONG_LOG  = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hold,
  input  logic                run,
  input  logic                long_sel,
  output logic [LONG_LOG-1:0] cnt,
  output logic                wrap,
  output logic                late
);
  localparam logic [LONG_LOG-1:0] LIM_S = LONG_LOG'((1 << SHORT_LOG) - 1);
  localparam logic [LONG_LOG-1:0] LIM_L = LONG_LOG'((1 << LONG_LOG) - 1);
  localparam logic [LONG_LOG-1:0] THR_S = LONG_LOG'(3 << (SHORT_LOG - 2));
  localparam logic [LONG_LOG-1:0] THR_L = LONG_LOG'(3 << (LONG_LOG - 2));

  logic [LONG_LOG-1:0] lim, thr;

  always_comb begin
    lim = long_sel ? LIM_L : LIM_S;
    thr = long_sel ? THR_L : THR_S;
  end

  assign wrap = run & ~hold & (cnt == lim);
  assign late = (cnt >= thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (hold)   cnt <= '0;
    else if (run)    cnt <= wrap ? '0 : cnt + 1'b1;
  end

  // R1: first-stage count never passes the selected terminal value
  a_r1_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= lim) else $error("a_r1_pre_bound");
endmodule

// File: rtl/wdog_postscaler.sv
module wdog_postscaler #(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              step,
  input  logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  cnt,
  output logic              term,
  output logic              late
);
  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] lim;
  logic [CNT_W+1:0] thr3;

  always_comb begin
    span = (CNT_W+1)'(1) << code;
    lim  = CNT_W'(span - 1'b1);
    thr3 = ({1'b0, span} + {span, 1'b0}) >> 2;
  end

  assign term = step & ~hold & (cnt == lim);
  assign late = ({2'b00, cnt} >= thr3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (hold)   cnt <= '0;
    else if (step)   cnt <= term ? '0 : cnt + 1'b1;
  end

  // R2: second-stage count stays inside the 2^n range
  a_r2_post_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= lim) else $error("a_r2_post_bound");
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_force_en,
  input  logic sw_en_wr,
  input  logic sw_en_din,
  input  logic early,
  input  logic timeout,
  input  logic sleep_idle,
  input  logic flag_clr,
  output logic enabled,
  output logic rst_req,
  output logic wake_req,
  output logic to_flag
);
  logic    sw_en_q;
  wd_evt_e evt;

  assign enabled = cfg_force_en | sw_en_q;

  always_comb begin
    if (early)        evt = WD_RESET;
    else if (timeout) evt = sleep_idle ? WD_WAKE : WD_RESET;
    else              evt = WD_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_en_q  <= 1'b0;
      rst_req  <= 1'b0;
      wake_req <= 1'b0;
      to_flag  <= 1'b0;
    end else begin
      if (sw_en_wr) sw_en_q <= sw_en_din;
      rst_req  <= (evt == WD_RESET);
      wake_req <= (evt == WD_WAKE);
      to_flag  <= (evt != WD_NONE) | (to_flag & ~flag_clr);
    end
  end

  // R5 / R7: a single event never asks for both reset and wake
  a_r5_one_req: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && wake_req)) else $error("a_r5_one_req");
  // R8: flag present whenever a request pulse is
  a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req || wake_req) |-> to_flag) else $error("a_r8_flag_set");
  // R8: flag holds until cleared
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (to_flag && !flag_clr) |=> to_flag) else $error("a_r8_sticky");
endmodule

// File: rtl/wdog_window.sv
module wdog_window #(
  parameter int PRE_SHORT_LOG = 5,
  parameter int PRE_LONG_LOG  = 7,
  parameter int POST_CODE_W   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   cfg_pre_long,
  input  logic [POST_CODE_W-1:0] cfg_post_code,
  input  logic                   cfg_force_en,
  input  logic                   cfg_win_off,
  input  logic                   sw_en_wr,
  input  logic                   sw_en_din,
  input  logic                   kick,
  input  logic                   ps_enter,
  input  logic                   ps_exit,
  input  logic                   clk_sw_done,
  input  logic                   sleep_idle,
  input  logic                   flag_clr,
  output logic                   rst_req,
  output logic                   wake_req,
  output logic                   to_flag
);
  localparam int POST_CNT_W = (1 << POST_CODE_W) - 1;

  logic                    enabled, restart, hold, run;
  logic                    pre_wrap, pre_late, post_term, post_late;
  logic                    window_ok, early;
  logic [PRE_LONG_LOG-1:0] pre_cnt;
  logic [POST_CNT_W-1:0]   post_cnt;

  assign restart   = kick | ps_enter | ps_exit | clk_sw_done;
  assign hold      = restart | ~enabled;
  assign run       = tick & enabled;
  assign window_ok = (cfg_post_code == '0) ? pre_late : post_late;
  assign early     = enabled & kick & ~cfg_win_off & ~window_ok;

  wdog_prescaler #(
    .SHORT_LOG (PRE_SHORT_LOG),
    .LONG_LOG  (PRE_LONG_LOG)
  ) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (hold),
    .run      (run),
    .long_sel (cfg_pre_long),
    .cnt      (pre_cnt),
    .wrap     (pre_wrap),
    .late     (pre_late)
  );

  wdog_postscaler #(
    .CODE_W (POST_CODE_W),
    .CNT_W  (POST_CNT_W)
  ) u_post (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (hold),
    .step  (pre_wrap),
    .code  (cfg_post_code),
    .cnt   (post_cnt),
    .term  (post_term),
    .late  (post_late)
  );

  wdog_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_force_en (cfg_force_en),
    .sw_en_wr     (sw_en_wr),
    .sw_en_din    (sw_en_din),
    .early        (early),
    .timeout      (post_term),
    .sleep_idle   (sleep_idle),
    .flag_clr     (flag_clr),
    .enabled      (enabled),
    .rst_req      (rst_req),
    .wake_req     (wake_req),
    .to_flag      (to_flag)
  );

  // R3: any restart source leaves both stages at zero
  a_r3_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pre_cnt == '0 && post_cnt == '0)) else $error("a_r3_restart_zero");
  // R9: a disabled timer raises no request on the following cycle
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |=> (!rst_req && !wake_req)) else $error("a_r9_quiet");
endmodule

// File: tb/wdog_window_bench.sv
module wdog_window_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, cfg_pre_long = 1'b0, cfg_force_en = 1'b0, cfg_win_off = 1'b1;
  logic [3:0] cfg_post_code = 4'd0;
  logic       sw_en_wr = 1'b0, sw_en_din = 1'b0, kick = 1'b0, ps_enter = 1'b0;
  logic       ps_exit = 1'b0, clk_sw_done = 1'b0, sleep_idle = 1'b0, flag_clr = 1'b0;
  logic       rst_req, wake_req, to_flag;

  int    checks = 0, failures = 0, cyc = 0;
  int    n_rst = 0, n_wake = 0;
  string phase = "R4";

  // reference model state
  int m_pre = 0, m_post = 0;
  bit m_sw = 0, m_rst = 0, m_wake = 0, m_flag = 0;
  int plim, qlim;
  bit en, rs, inw, early, expire, nr, nw;

  always #10 clk = ~clk;

  wdog_window u_wdog_window (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_pre_long(cfg_pre_long),
    .cfg_post_code(cfg_post_code), .cfg_force_en(cfg_force_en), .cfg_win_off(cfg_win_off),
    .sw_en_wr(sw_en_wr), .sw_en_din(sw_en_din), .kick(kick), .ps_enter(ps_enter),
    .ps_exit(ps_exit), .clk_sw_done(clk_sw_done), .sleep_idle(sleep_idle),
    .flag_clr(flag_clr), .rst_req(rst_req), .wake_req(wake_req), .to_flag(to_flag)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_post = 0; m_sw = 0; m_rst = 0; m_wake = 0; m_flag = 0;
    end else begin
      plim = cfg_pre_long ? 128 : 32;
      qlim = 1 << cfg_post_code;
      en   = cfg_force_en || m_sw;
      rs   = kick || ps_enter || ps_exit || clk_sw_done;
      nr = 0; nw = 0;
      if (!en) begin
        m_pre = 0; m_post = 0;
      end else begin
        inw    = (cfg_post_code == 0) ? (m_pre >= (plim * 3) / 4) : (m_post >= (3 * qlim) / 4);
        early  = kick && !cfg_win_off && !inw;
        expire = tick && !rs && m_pre == plim - 1 && m_post == qlim - 1;
        if (rs) begin
          m_pre = 0; m_post = 0;
        end else if (tick) begin
          if (m_pre == plim - 1) begin
            m_pre = 0;
            m_post = (m_post == qlim - 1) ? 0 : m_post + 1;
          end else m_pre = m_pre + 1;
        end
        nr = early || (expire && !sleep_idle);
        nw = expire && sleep_idle && !early;
      end
      m_flag = (nr || nw) ? 1'b1 : (flag_clr ? 1'b0 : m_flag);
      m_rst  = nr;
      m_wake = nw;
      if (sw_en_wr) m_sw = sw_en_din;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(phase, "rst_req", rst_req, m_rst);
      check(phase, "wake_req", wake_req, m_wake);
      check(phase, "to_flag", to_flag, m_flag);
      if (rst_req) n_rst++;
      if (wake_req) n_wake++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<100000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic run(int n, int stride = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = (i % stride == 0);
    end
    @(negedge clk);
    tick = 1'b1;
  endtask

  task automatic pulse_kick();
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
  endtask

  task automatic reconfig(bit pl, int code, bit woff);
    @(negedge clk);
    cfg_force_en = 1'b0; sw_en_wr = 1'b1; sw_en_din = 1'b0;
    @(negedge clk); sw_en_wr = 1'b0;
    @(negedge clk);
    cfg_pre_long = pl; cfg_post_code = 4'(code); cfg_win_off = woff;
    @(negedge clk); cfg_force_en = 1'b1;
  endtask

  initial begin
    tick = 1'b1; cfg_force_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R4", "rst_req at reset", rst_req, 0);
    check("R4", "wake_req at reset", wake_req, 0);
    check("R4", "to_flag at reset", to_flag, 0);
    rst_n = 1'b1;

    phase = "R5"; n_rst = 0;
    run(69);
    check("R5", "reset pulses in 70 ticks", n_rst, 2);

    phase = "R8";
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    run(5);

    phase = "R1"; reconfig(1'b1, 0, 1'b1); run(140);
    phase = "R2"; reconfig(1'b0, 3, 1'b1); run(260);

    phase = "R6"; reconfig(1'b0, 3, 1'b0); n_rst = 0;
    run(100); pulse_kick();
    run(200); pulse_kick();
    run(50);
    check("R6", "early kick reset seen", (n_rst >= 1) ? 1 : 0, 1);
    reconfig(1'b0, 0, 1'b0);
    run(10); pulse_kick();
    run(23); pulse_kick();
    run(24); pulse_kick();
    run(26); pulse_kick();
    run(10);

    phase = "R10"; reconfig(1'b0, 0, 1'b1);
    run(5); pulse_kick(); run(40);

    phase = "R7"; pulse_kick(); sleep_idle = 1'b1; n_wake = 0;
    run(39);
    check("R7", "wake pulses in sleep", n_wake, 1);
    sleep_idle = 1'b0;

    phase = "R3";
    run(20); @(negedge clk); ps_enter = 1'b1; @(negedge clk); ps_enter = 1'b0;
    run(20); @(negedge clk); ps_exit = 1'b1; @(negedge clk); ps_exit = 1'b0;
    run(20); @(negedge clk); clk_sw_done = 1'b1; @(negedge clk); clk_sw_done = 1'b0;
    run(40);

    phase = "R9"; reconfig(1'b0, 0, 1'b1); cfg_force_en = 1'b0; n_rst = 0;
    run(100);
    check("R9", "no reset while disabled", n_rst, 0);

    phase = "R4";
    @(negedge clk); sw_en_wr = 1'b1; sw_en_din = 1'b1;
    @(negedge clk); sw_en_wr = 1'b0;
    run(40);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R4", "flag after reset", to_flag, 0);
    rst_n = 1'b1; n_rst = 0;
    run(60);
    check("R4", "software enable cleared by reset", n_rst, 0);

    phase = "R1"; cfg_force_en = 1'b1; @(negedge clk); clk_sw_done = 1'b1;
    @(negedge clk); clk_sw_done = 1'b0;
    run(120, 3);
    run(10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule